// File: doc/BRIEF.md
# Protected Clock Register Bank Controller

This block holds the 48-byte register file of a real-time-clock device. A byte-level serial front end drives it with four kinds of event: bus start, bus stop, a received byte, and a request for the next read byte. The first byte after a start is a device-select byte. The block responds only to its own device identity and ignores every other transaction, including those meant for a neighbouring SRAM.

In a write transaction, the first data byte loads the address pointer. Each later byte is stored at the pointer, and the pointer then advances and wraps from 2Fh back to 00h. The seven clock bytes at 00h–06h are write-protected. Bus writes to them take effect only while bit 6 of register 08h is set.

When a read-direction select byte is accepted, the clock bytes are copied into a buffer. Reads of 00h–06h are served from that buffer until the stop event. Meanwhile, a separate timekeeper port keeps updating the live registers. The pointer survives the stop event, so a later read that sends no address continues where the last transfer ended.

Top module: `rtc_regbank_ctrl`

## Requirements
- R1: Only a select byte whose upper seven bits equal 1101111b opens a transaction; bit 0 set means read and bit 0 clear means write. Any other select byte, for example 1010111x, leaves `sel_active` low, and no byte of that transaction writes a register or moves the pointer.
- R2: After reset, address 03h, 04h, 07h and 08h hold 01h, address 0Bh holds 20h, address 0Ch holds 46h, and every other address up to 2Fh holds 00h.
- R3: In a write transaction, the first byte after the select byte loads the pointer. A value above 2Fh loads 00h.
- R4: Every later byte of a write transaction advances the pointer by one, and the pointer wraps from 2Fh to 00h.
- R5: A bus write to 00h–06h while bit 6 of register 08h is 0 is discarded, and the pointer still advances.
- R6: Bus writes to 07h–2Fh take effect whatever bit 6 of register 08h holds.
- R7: A read request in a read transaction makes `rd_vld` pulse one cycle later, with `rd_data` holding the byte at the pointer. The pointer then advances with the same wrap as R4.
- R8: The clock bytes are copied when a read select byte is accepted. Until stop, reads of 00h–06h return the copy even after timekeeper updates; after stop, reads return the updated values.
- R9: After stop, the pointer keeps its value, so a read transaction that sends no address starts at the byte after the last one transferred.
- R10: A timekeeper write with `tk_addr` 0–6 updates that clock byte, and `tk_addr` 7 is ignored. If an accepted bus write hits the same byte in the same cycle, the bus value is stored.
- R11: Stop takes priority over start in the same cycle and returns the block to idle. A start in any state begins a new select phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_start | input | 1 | Start or repeated-start event |
| bus_stop | input | 1 | Stop event |
| bus_byte_vld | input | 1 | A byte from the bus master is present |
| bus_byte | input | 8 | Byte from the bus master |
| bus_rd_req | input | 1 | Master requests the next read byte |
| tk_we | input | 1 | Timekeeper write strobe |
| tk_addr | input | 3 | Timekeeper clock-byte index |
| tk_data | input | 8 | Timekeeper write data |
| rd_data | output | 8 | Read byte, valid with `rd_vld` |
| rd_vld | output | 1 | Read byte valid pulse |
| sel_active | output | 1 | The block is addressed in the current transaction |

## Verification
The bench builds the block with its default parameters: 48 registers, seven protected clock bytes, the enable at bit 6 of 08h, and the snapshot variant selected. With 48 addresses, the bench can read the whole bank to confirm the reset image. It also drives both reads and writes across the 2Fh-to-00h wrap. The seven-byte clock section allows every protected byte to be overwritten by the timekeeper while a snapshot read is in progress.

// File: rtl/rtc_rb_pkg.sv
package rtc_rb_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SEL, ST_WADDR, ST_WDATA, ST_READ, ST_SKIP
   } bus_st_e;

   function automatic logic [BYTE_W-1:0] rst_val(int idx);
      case (idx)
         3, 4, 7, 8: return 8'h01;
         11:         return 8'h20;
         12:         return 8'h46;
         default:    return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/rtc_rb_fsm.sv
module rtc_rb_fsm
   import rtc_rb_pkg::*;
#(
   parameter logic [6:0] DEV_ID = 7'b1101111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              rd_req,
   output bus_st_e           state,
   output logic              load_ptr,
   output logic              wr_en,
   output logic              rd_en,
   output logic              snap_take
);
   logic    evt_ok, id_hit;
   bus_st_e nxt;

   always_comb begin
      evt_ok    = !start && !stop;
      id_hit    = byte_in[BYTE_W-1:1] == DEV_ID;
      load_ptr  = evt_ok && byte_vld && state == ST_WADDR;
      wr_en     = evt_ok && byte_vld && state == ST_WDATA;
      rd_en     = evt_ok && rd_req && state == ST_READ;
      snap_take = evt_ok && byte_vld && state == ST_SEL && id_hit && byte_in[0];
      nxt       = state;
      if (stop)
         nxt = ST_IDLE;
      else if (start)
         nxt = ST_SEL;
      else if (byte_vld) begin
         case (state)
            ST_SEL:   nxt = !id_hit ? ST_SKIP : (byte_in[0] ? ST_READ : ST_WADDR);
            ST_WADDR: nxt = ST_WDATA;
            default:  nxt = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R1: a foreign device identity parks the transaction
   p_foreign_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SEL && byte_vld && !start && !stop && byte_in[BYTE_W-1:1] != DEV_ID)
      |=> state == ST_SKIP);

   // R11: stop always returns to idle
   p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> state == ST_IDLE);
endmodule

// File: rtl/rtc_rb_ptr.sv
module rtc_rb_ptr
   import rtc_rb_pkg::*;
#(
   parameter int NREG = 48,
   parameter int AW   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              adv,
   output logic [AW-1:0]     ptr
);
   localparam logic [AW-1:0] LAST = AW'(NREG - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= (int'(load_val) < NREG) ? load_val[AW-1:0] : '0;
      else if (adv)
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   p_load_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && int'(load_val) >= NREG) |=> ptr == '0);

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && ptr == LAST) |=> ptr == '0);

   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/rtc_rb_store.sv
module rtc_rb_store
   import rtc_rb_pkg::*;
#(
   parameter int NREG     = 48,
   parameter int AW       = $clog2(NREG),
   parameter int CLK_REGS = 7,
   parameter int TAW      = $clog2(CLK_REGS),
   parameter int WEN_ADDR = 8,
   parameter int WEN_BIT  = 6,
   parameter bit SNAP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     ptr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              tk_we,
   input  logic [TAW-1:0]    tk_addr,
   input  logic [BYTE_W-1:0] tk_data,
   input  logic              snap_take,
   input  logic              snap_drop,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_vld
);
   localparam int LW = CLK_REGS * BYTE_W;

   logic [BYTE_W-1:0] regs [NREG];
   logic [BYTE_W-1:0] snap [CLK_REGS];
   logic [LW-1:0]     live_vec, snap_vec;
   logic              hold, wen, in_clk, bus_acc, tk_ok;
   logic [BYTE_W-1:0] rd_src;

   always_comb begin
      wen     = regs[WEN_ADDR][WEN_BIT];
      in_clk  = int'(ptr) < CLK_REGS;
      bus_acc = wr_en && (!in_clk || wen);
      tk_ok   = tk_we && int'(tk_addr) < CLK_REGS;
   end

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [BYTE_W-1:0] RV = rst_val(i);
      if (i < CLK_REGS) begin : g_clk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               regs[i] <= RV;
            else if (bus_acc && ptr == AW'(i))        regs[i] <= wdata;
            else if (tk_ok && tk_addr == TAW'(i))     regs[i] <= tk_data;
         end
         assign live_vec[i*BYTE_W +: BYTE_W] = regs[i];
      end else begin : g_gen
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        regs[i] <= RV;
            else if (bus_acc && ptr == AW'(i)) regs[i] <= wdata;
         end
      end
   end

   if (SNAP_EN) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         hold <= 1'b0;
         else if (snap_take) hold <= 1'b1;
         else if (snap_drop) hold <= 1'b0;
      end
      for (genvar j = 0; j < CLK_REGS; j++) begin : g_sb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         snap[j] <= '0;
            else if (snap_take) snap[j] <= regs[j];
         end
         assign snap_vec[j*BYTE_W +: BYTE_W] = snap[j];
      end

      // R8: the held copy is frozen until the next capture
      p_snap_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (hold && !snap_take) |=> $stable(snap_vec));
   end else begin : g_live
      assign hold = 1'b0;
      for (genvar j = 0; j < CLK_REGS; j++) begin : g_tie
         assign snap[j] = '0;
         assign snap_vec[j*BYTE_W +: BYTE_W] = '0;
      end
   end

   always_comb begin
      if (in_clk && hold) rd_src = snap[ptr[TAW-1:0]];
      else                rd_src = regs[ptr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_vld  <= 1'b0;
      end else begin
         rd_vld <= rd_en;
         if (rd_en) rd_data <= rd_src;
      end
   end

   // R5: a protected clock byte ignores the bus while the enable is clear
   p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_clk && !wen && !tk_we) |=> $stable(live_vec));

   p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_vld);
endmodule

// File: rtl/rtc_regbank_ctrl.sv
module rtc_regbank_ctrl
   import rtc_rb_pkg::*;
#(
   parameter int         NREG     = 48,
   parameter int         CLK_REGS = 7,
   parameter int         WEN_ADDR = 8,
   parameter int         WEN_BIT  = 6,
   parameter logic [6:0] DEV_ID   = 7'b1101111,
   parameter bit         SNAP_EN  = 1'b1,
   localparam int        AW       = $clog2(NREG),
   localparam int        TAW      = $clog2(CLK_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic              bus_byte_vld,
   input  logic [BYTE_W-1:0] bus_byte,
   input  logic              bus_rd_req,
   input  logic              tk_we,
   input  logic [TAW-1:0]    tk_addr,
   input  logic [BYTE_W-1:0] tk_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              sel_active
);
   if (NREG < 2 || NREG > 255) begin : g_bad_nreg
      $error("NREG out of range");
   end
   if (CLK_REGS < 2 || CLK_REGS > NREG) begin : g_bad_clk
      $error("CLK_REGS out of range");
   end
   if (WEN_ADDR < CLK_REGS || WEN_ADDR >= NREG) begin : g_bad_wen
      $error("WEN_ADDR must lie outside the clock section");
   end
   if (WEN_BIT < 0 || WEN_BIT >= BYTE_W) begin : g_bad_bit
      $error("WEN_BIT out of range");
   end

   bus_st_e       state;
   logic          load_ptr, wr_en, rd_en, snap_take;
   logic [AW-1:0] ptr;

   rtc_rb_fsm #(.DEV_ID(DEV_ID)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(bus_start), .stop(bus_stop),
      .byte_vld(bus_byte_vld), .byte_in(bus_byte), .rd_req(bus_rd_req),
      .state(state), .load_ptr(load_ptr), .wr_en(wr_en), .rd_en(rd_en),
      .snap_take(snap_take)
   );

   rtc_rb_ptr #(.NREG(NREG), .AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load(load_ptr), .load_val(bus_byte),
      .adv(wr_en || rd_en), .ptr(ptr)
   );

   rtc_rb_store #(
      .NREG(NREG), .AW(AW), .CLK_REGS(CLK_REGS), .TAW(TAW),
      .WEN_ADDR(WEN_ADDR), .WEN_BIT(WEN_BIT), .SNAP_EN(SNAP_EN)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .ptr(ptr), .wr_en(wr_en), .wdata(bus_byte),
      .tk_we(tk_we), .tk_addr(tk_addr), .tk_data(tk_data),
      .snap_take(snap_take), .snap_drop(bus_stop), .rd_en(rd_en),
      .rd_data(rd_data), .rd_vld(rd_vld)
   );

   assign sel_active = (state == ST_WADDR) || (state == ST_WDATA) || (state == ST_READ);
endmodule

// File: tb/rtc_regbank_ctrl_test.sv
module rtc_regbank_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 0, bus_stop = 0, bus_byte_vld = 0, bus_rd_req = 0;
   logic [7:0] bus_byte = 0;
   logic       tk_we = 0;
   logic [2:0] tk_addr = 0;
   logic [7:0] tk_data = 0;
   logic [7:0] rd_data;
   logic       rd_vld, sel_active;

   int    total = 0, bad = 0;
   string cur_req = "R2";
   bit    done = 0;

   always #5 clk = ~clk;

   rtc_regbank_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
      .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte), .bus_rd_req(bus_rd_req),
      .tk_we(tk_we), .tk_addr(tk_addr), .tk_data(tk_data),
      .rd_data(rd_data), .rd_vld(rd_vld), .sel_active(sel_active)
   );

   // behavioural reference: mode 0 idle, 1 select, 2 address, 3 data, 4 read, 5 foreign
   int mem [48];
   int snap [7];
   int snap_on, mode, ptr, exp_data, exp_vld;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 48; i++) mem[i] = 0;
         mem[3] = 1; mem[4] = 1; mem[7] = 1; mem[8] = 1; mem[11] = 'h20; mem[12] = 'h46;
         snap_on = 0; mode = 0; ptr = 0; exp_vld = 0; exp_data = 0;
      end else begin
         int old [48];
         int bus_w, quiet;
         for (int i = 0; i < 48; i++) old[i] = mem[i];
         quiet   = !bus_start && !bus_stop;
         exp_vld = 0;
         bus_w   = quiet && bus_byte_vld && mode == 3 && (ptr >= 7 || old[8][6]);
         if (tk_we && tk_addr < 7 && !(bus_w && ptr == tk_addr)) mem[tk_addr] = tk_data;
         if (bus_stop) begin
            mode = 0; snap_on = 0;
         end else if (bus_start) begin
            mode = 1;
         end else if (bus_byte_vld) begin
            if (mode == 1) begin
               if (bus_byte[7:1] != 7'h6F) mode = 5;
               else if (bus_byte[0]) begin
                  for (int i = 0; i < 7; i++) snap[i] = old[i];
                  snap_on = 1; mode = 4;
               end else mode = 2;
            end else if (mode == 2) begin
               ptr = (bus_byte < 48) ? bus_byte : 0; mode = 3;
            end else if (mode == 3) begin
               if (bus_w) mem[ptr] = bus_byte;
               ptr = (ptr + 1) % 48;
            end
         end else if (bus_rd_req && mode == 4) begin
            exp_data = (ptr < 7 && snap_on) ? snap[ptr] : old[ptr];
            exp_vld  = 1;
            ptr      = (ptr + 1) % 48;
         end
      end
   end

   task automatic check(string tag, int act, int exp, string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, rd_vld, exp_vld, "rd_vld");
         check("R1", sel_active, (mode >= 2 && mode <= 4), "sel_active");
         if (exp_vld) check(cur_req, rd_data, exp_data, "rd_data");
      end
   end

   task automatic pulse_start(); bus_start = 1; @(negedge clk); bus_start = 0; endtask
   task automatic pulse_stop();  bus_stop  = 1; @(negedge clk); bus_stop  = 0; endtask
   task automatic send(input logic [7:0] b);
      bus_byte_vld = 1; bus_byte = b; @(negedge clk); bus_byte_vld = 0;
   endtask
   task automatic rdreq(); bus_rd_req = 1; @(negedge clk); bus_rd_req = 0; endtask
   task automatic tk(input logic [2:0] a, input logic [7:0] d);
      tk_we = 1; tk_addr = a; tk_data = d; @(negedge clk); tk_we = 0;
   endtask
   task automatic wr(input logic [7:0] a, input int n, input logic [7:0] base);
      pulse_start(); send(8'hDE); send(a);
      for (int i = 0; i < n; i++) send(base + 8'(i));
      pulse_stop();
   endtask
   task automatic rd(input logic [7:0] a, input int n);
      pulse_start(); send(8'hDE); send(a); pulse_start(); send(8'hDF);
      for (int i = 0; i < n; i++) rdreq();
      pulse_stop();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R2";  rd(8'h00, 48);
      cur_req = "R6";  wr(8'h20, 3, 8'hA0); rd(8'h20, 3);
      cur_req = "R5";  wr(8'h00, 2, 8'h12); rd(8'h00, 3);
      cur_req = "R6";  wr(8'h08, 1, 8'h41); rd(8'h07, 2);
      cur_req = "R4";  wr(8'h2E, 3, 8'h55); rd(8'h2D, 4);
      cur_req = "R3";  wr(8'h70, 1, 8'h3C); rd(8'h00, 1);
      cur_req = "R1";
      pulse_start(); send(8'hAE); send(8'h05); send(8'h99); pulse_stop();
      pulse_start(); send(8'hAF); rdreq(); pulse_stop();
      rd(8'h05, 1);
      cur_req = "R8";
      pulse_start(); send(8'hDE); send(8'h00); pulse_start(); send(8'hDF); rdreq();
      for (int i = 0; i < 7; i++) tk(3'(i), 8'h60 + 8'(i));
      rdreq(); rdreq(); rdreq(); pulse_stop();
      rd(8'h00, 7);
      cur_req = "R9";
      pulse_start(); send(8'hDF); rdreq(); rdreq(); pulse_stop();
      cur_req = "R10";
      tk(3'd7, 8'hEE); rd(8'h07, 1);
      pulse_start(); send(8'hDE); send(8'h02);
      bus_byte_vld = 1; bus_byte = 8'h77; tk_we = 1; tk_addr = 3'd2; tk_data = 8'h11;
      @(negedge clk); bus_byte_vld = 0; tk_we = 0;
      pulse_stop(); rd(8'h02, 1);
      cur_req = "R11";
      pulse_start(); send(8'hDE);
      bus_start = 1; bus_stop = 1; @(negedge clk); bus_start = 0; bus_stop = 0;
      send(8'h00); send(8'h00); rd(8'h00, 1);
      cur_req = "R7";  rd(8'h2F, 2);
      @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog %s: actual=hung expected=finished", cur_req);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule